// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one general-purpose I/O port of up to sixteen pins. Software programs each pin through a small word-addressed register bus. Each pin has a 2-bit mode field, a 2-bit control field and one speed-extension bit. From these the block decodes the pad controls: output value, output enable, open-drain select, pull-up enable, pull-down enable, analog select and a 2-bit speed code. Pad inputs pass through a two-stage synchronizer and land in an input status register, which software reads.

With the mode field at zero the pin is an input. It is analog, floating or pulled, and in the pulled case the pin's output-data bit picks the pull direction. Any nonzero mode makes the pin an output and also sets its speed grade. The control field then chooses between the output-data register and the pin's alternate-function source, and between push-pull and open-drain. A set/clear register changes output bits in a single write. A per-port flag warns when a pin sits at the top speed grade while the compensation enable is clear. A per-pin flag marks the one reserved encoding.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin has mode 00 and control 01 (floating input) and no pull resistor, except pin 15 and pin 14. Both of those reset to control 10 (pulled input): pin 15 with output bit 1 (pull-up) and pin 14 with output bit 0 (pull-down). All output enables, analog selects, error flags and the compensation warning are 0 out of reset.
- R2: Mode 00 with control 00 is analog. pad_ana is 1, and pad_oe, pad_pu, pad_pd and pad_out are 0 whatever the output bit holds.
- R3: Mode 00 with control 01 or 11 is a floating input. Every pad control is 0 whatever the output bit holds.
- R4: Mode 00 with control 10 is a pulled input. pad_pu equals the output bit and pad_pd is its inverse, so the two are never both 1.
- R5: A nonzero mode with control 00 is push-pull from the output register: pad_oe is 1, pad_out equals the output bit, and pad_od is 0.
- R6: Control bit 0 set in a nonzero mode selects open-drain, and pad_od is 1. A source value of 0 gives pad_oe 1 with pad_out 0. A source value of 1 gives pad_oe 0. pad_out is always 0.
- R7: Control bit 1 set in a nonzero mode selects the alternate-function source. The value comes from af_out and the enable from af_oe, and the output bit has no effect.
- R8: The speed code on pad_spd[2i+1:2i] is 01 for mode 01, 00 for mode 10, 10 for mode 11 with the speed bit clear, and 11 for mode 11 with the speed bit set. It is 00 in input modes.
- R9: Mode 00 with the speed bit set is reserved. The pin behaves exactly as the input selected by its control field, and cfg_err for that pin is 1. cfg_err is 0 for every other encoding.
- R10: comp_warn is 1 exactly when at least one pin has speed code 11 and the compensation enable (bit 0 at address 6) is 0.
- R11: The input status register (address 4, bits [N-1:0]) shows pad_in three clock edges after a change. Two edges are synchronizer stages and one edge is the status register. A pin in analog mode reads 0.
- R12: A write to address 5 sets the output bits given in wdata[N-1:0] and clears those given in wdata[16+N-1:16]. Set wins when both name the same pin. A write to address 3 loads the output register directly. Address 5 reads 0.
- R13: Register map. Address 0 holds pins 0-7 and address 1 holds pins 8-15, four bits per pin at [4k+3:4k] for slot k, with the mode in the low two bits and control in the high two. Address 2 holds the speed bits, address 3 the output bits, address 4 the input status and address 6 the compensation enable. Writes take effect at the clock edge and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NPINS | Raw pad input levels |
| af_out | input | NPINS | Alternate-function output value per pin |
| af_oe | input | NPINS | Alternate-function output enable per pin |
| pad_out | output | NPINS | Pad drive value |
| pad_oe | output | NPINS | Pad output enable |
| pad_od | output | NPINS | Open-drain select |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| pad_ana | output | NPINS | Analog select |
| pad_spd | output | 2*NPINS | Speed code, two bits per pin |
| cfg_err | output | NPINS | Reserved-encoding flag per pin |
| comp_warn | output | 1 | Top speed grade without compensation enable |

## Verification
The bench sweeps every combination of mode, control, speed bit, output bit and both alternate-function inputs. It compares all pad controls against an arithmetic model. This sweep exposes a decoder that lets the output bit leak into analog or floating pins, that swaps the pull direction, or that drives high in open-drain. It also exposes a decoder that reads the output register in alternate-function mode, or that gives the reserved encoding an output speed. The debug-pin reset values are checked directly, so a wrong pull polarity after reset shows up. The input path is sampled one edge before and one edge after the expected arrival, which catches a synchronizer that is a stage short or a stage long. The set/clear write names the same pin in both halves, which exposes clear-wins priority.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef struct packed {
        logic       out;
        logic       oe;
        logic       od;
        logic       pu;
        logic       pd;
        logic       ana;
        logic [1:0] spd;
        logic       err;
    } pad_ctl_t;

    localparam logic [2:0] ADR_CFG_LO = 3'd0;
    localparam logic [2:0] ADR_CFG_HI = 3'd1;
    localparam logic [2:0] ADR_SPD    = 3'd2;
    localparam logic [2:0] ADR_ODR    = 3'd3;
    localparam logic [2:0] ADR_IDR    = 3'd4;
    localparam logic [2:0] ADR_BSR    = 3'd5;
    localparam logic [2:0] ADR_CMP    = 3'd6;

    localparam logic [1:0] SPD_2M   = 2'b00;
    localparam logic [1:0] SPD_10M  = 2'b01;
    localparam logic [1:0] SPD_50M  = 2'b10;
    localparam logic [1:0] SPD_TOP  = 2'b11;

endpackage

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] ctl,
    input  logic       spd_bit,
    input  logic       odr_bit,
    input  logic       af_out,
    input  logic       af_oe,
    output pad_ctl_t   pc
);
    logic src_val;
    logic src_en;

    always_comb begin
        pc      = '0;
        src_val = ctl[1] ? af_out : odr_bit;
        src_en  = ctl[1] ? af_oe  : 1'b1;
        if (mode == 2'b00) begin
            // reserved encoding still decodes as an input
            pc.err = spd_bit;
            case (ctl)
                2'b00:   pc.ana = 1'b1;
                2'b10: begin
                    pc.pu = odr_bit;
                    pc.pd = ~odr_bit;
                end
                default: ;
            endcase
        end else begin
            pc.od = ctl[0];
            if (ctl[0]) begin
                pc.oe  = src_en & ~src_val;
                pc.out = 1'b0;
            end else begin
                pc.oe  = src_en;
                pc.out = src_val;
            end
            case (mode)
                2'b01:   pc.spd = SPD_10M;
                2'b10:   pc.spd = SPD_2M;
                default: pc.spd = spd_bit ? SPD_TOP : SPD_50M;
            endcase
        end
    end

    always_comb begin
        if (pc.ana) assert (!pc.oe && !pc.pu && !pc.pd) else $error("analog pin drives"); // R2
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] ana_mask,
    output logic [NPINS-1:0] idr
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] idr;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d     = sy_q;
        sy_d.s1  = pad_in;
        sy_d.s2  = sy_q.s1;
        sy_d.idr = sy_q.s2 & ~ana_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign idr = sy_q.idr;

    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((idr & $past(ana_mask)) == '0)); // R11
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int               NPINS   = 16,
    parameter logic [2*NPINS-1:0] RST_CTL = {2'b10, 2'b10, {(NPINS-2){2'b01}}},
    parameter logic [NPINS-1:0]   RST_ODR = {1'b1, {(NPINS-1){1'b0}}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    input  logic [NPINS-1:0]   af_out,
    input  logic [NPINS-1:0]   af_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_od,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    output logic [NPINS-1:0]   pad_ana,
    output logic [2*NPINS-1:0] pad_spd,
    output logic [NPINS-1:0]   cfg_err,
    output logic               comp_warn
);
    localparam int LO_PINS = (NPINS < 8) ? NPINS : 8;
    localparam int HI_PINS = NPINS - LO_PINS;

    typedef struct packed {
        logic [NPINS-1:0][1:0] mode;
        logic [NPINS-1:0][1:0] ctl;
        logic [NPINS-1:0]      spd;
        logic [NPINS-1:0]      odr;
        logic                  comp;
    } regs_t;

    regs_t q, d;
    logic [NPINS-1:0] idr;
    logic [NPINS-1:0] top_grade;
    pad_ctl_t         pc [NPINS];

    // next-state
    always_comb begin
        d = q;
        if (bus_we) begin
            case (bus_addr)
                ADR_CFG_LO: for (int p = 0; p < LO_PINS; p++) begin
                    d.mode[p] = bus_wdata[4*p +: 2];
                    d.ctl[p]  = bus_wdata[4*p+2 +: 2];
                end
                ADR_CFG_HI: for (int p = 0; p < HI_PINS; p++) begin
                    d.mode[p+8] = bus_wdata[4*p +: 2];
                    d.ctl[p+8]  = bus_wdata[4*p+2 +: 2];
                end
                ADR_SPD: d.spd  = bus_wdata[NPINS-1:0];
                ADR_ODR: d.odr  = bus_wdata[NPINS-1:0];
                ADR_BSR: d.odr  = (q.odr & ~bus_wdata[16 +: NPINS]) | bus_wdata[NPINS-1:0];
                ADR_CMP: d.comp = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= '0;
            q.ctl  <= RST_CTL;
            q.spd  <= '0;
            q.odr  <= RST_ODR;
            q.comp <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // readback
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CFG_LO: for (int p = 0; p < LO_PINS; p++)
                bus_rdata[4*p +: 4] = {q.ctl[p], q.mode[p]};
            ADR_CFG_HI: for (int p = 0; p < HI_PINS; p++)
                bus_rdata[4*p +: 4] = {q.ctl[p+8], q.mode[p+8]};
            ADR_SPD: bus_rdata[NPINS-1:0] = q.spd;
            ADR_ODR: bus_rdata[NPINS-1:0] = q.odr;
            ADR_IDR: bus_rdata[NPINS-1:0] = idr;
            ADR_CMP: bus_rdata[0]         = q.comp;
            default: ;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_decode u_dec (
            .mode    (q.mode[i]),
            .ctl     (q.ctl[i]),
            .spd_bit (q.spd[i]),
            .odr_bit (q.odr[i]),
            .af_out  (af_out[i]),
            .af_oe   (af_oe[i]),
            .pc      (pc[i])
        );
        assign pad_out[i]       = pc[i].out;
        assign pad_oe[i]        = pc[i].oe;
        assign pad_od[i]        = pc[i].od;
        assign pad_pu[i]        = pc[i].pu;
        assign pad_pd[i]        = pc[i].pd;
        assign pad_ana[i]       = pc[i].ana;
        assign pad_spd[2*i +: 2] = pc[i].spd;
        assign cfg_err[i]       = pc[i].err;
        assign top_grade[i]     = (pc[i].spd == SPD_TOP);
    end

    assign comp_warn = (|top_grade) & ~q.comp;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .ana_mask (pad_ana),
        .idr      (idr)
    );

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0); // R4
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od & pad_oe & pad_out) == '0); // R6
    AST_RESERVED_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err & (pad_oe | pad_od)) == '0); // R9
    AST_WARN_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        comp_warn |-> (pad_spd != '0)); // R10
    AST_BSR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_BSR) |=>
            ((q.odr & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R12
    AST_BSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_BSR) |=>
            ((q.odr & $past(bus_wdata[16 +: NPINS] & ~bus_wdata[NPINS-1:0])) == '0)); // R12
endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0, af_out = '0, af_oe = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ana, cfg_err;
    logic [2*N-1:0] pad_spd;
    logic          comp_warn;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .af_out(af_out), .af_oe(af_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ana(pad_ana),
        .pad_spd(pad_spd), .cfg_err(cfg_err), .comp_warn(comp_warn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    // returns {err, spd[1:0], ana, pd, pu, od, oe, out}
    function automatic logic [8:0] model(input int m, input int c, input bit s,
                                         input bit o, input bit a, input bit e);
        logic out_v, oe_v, od_v, pu_v, pd_v, ana_v, err_v, val, en;
        logic [1:0] sp;
        {out_v, oe_v, od_v, pu_v, pd_v, ana_v, err_v} = '0;
        sp = 2'b00;
        if (m == 0) begin
            err_v = s;
            ana_v = (c == 0);
            pu_v  = (c == 2) && o;
            pd_v  = (c == 2) && !o;
        end else begin
            val  = (c >= 2) ? a : o;
            en   = (c >= 2) ? e : 1'b1;
            od_v = c[0];
            oe_v = od_v ? (en && !val) : en;
            out_v = od_v ? 1'b0 : val;
            sp = (m == 1) ? 2'b01 : (m == 2) ? 2'b00 : (s ? 2'b11 : 2'b10);
        end
        return {err_v, sp, ana_v, pd_v, pu_v, od_v, oe_v, out_v};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [8:0]  x;
        string       tg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pu", 32'(pad_pu), 32'h8000);
        chk("R1 pd", 32'(pad_pd), 32'h4000);
        chk("R1 oe", 32'(pad_oe), 32'h0);
        chk("R1 ana", 32'(pad_ana), 32'h0);
        chk("R1 err/warn", {15'd0, comp_warn, cfg_err}, 32'h0);
        rd(3'd0, r); chk("R1 R13 cfg lo", r, 32'h44444444);
        rd(3'd1, r); chk("R1 R13 cfg hi", r, 32'h88444444);
        rd(3'd3, r); chk("R1 R13 odr", r, 32'h00008000);

        // sweep of every per-pin encoding, all pins identical
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                for (int s = 0; s < 2; s++)
                    for (int o = 0; o < 2; o++)
                        for (int a = 0; a < 2; a++)
                            for (int e = 0; e < 2; e++) begin
                                logic [3:0] nib;
                                nib = {c[1:0], m[1:0]};
                                wr(3'd0, {8{nib}});
                                wr(3'd1, {8{nib}});
                                wr(3'd2, {16'd0, {16{s[0]}}});
                                wr(3'd3, {16'd0, {16{o[0]}}});
                                af_out = {16{a[0]}};
                                af_oe  = {16{e[0]}};
                                #0.5;
                                x = model(m, c, s[0], o[0], a[0], e[0]);
                                if (m == 0) tg = (c == 0) ? "R2" : (c == 2) ? "R4" : "R3";
                                else        tg = (c >= 2) ? "R7" : (c == 1) ? "R6" : "R5";
                                chk({tg, " out"}, 32'(pad_out), {16'd0, {16{x[0]}}});
                                chk({tg, " oe"},  32'(pad_oe),  {16'd0, {16{x[1]}}});
                                chk({tg, " od"},  32'(pad_od),  {16'd0, {16{x[2]}}});
                                chk({tg, " pu"},  32'(pad_pu),  {16'd0, {16{x[3]}}});
                                chk({tg, " pd"},  32'(pad_pd),  {16'd0, {16{x[4]}}});
                                chk({tg, " ana"}, 32'(pad_ana), {16'd0, {16{x[5]}}});
                                chk("R8 speed", pad_spd, {16{x[7:6]}});
                                chk("R9 cfg_err", 32'(cfg_err), {16'd0, {16{x[8]}}});
                            end

        // R10 compensation warning
        wr(3'd0, 32'h33333333);
        wr(3'd1, 32'h44444444);
        wr(3'd2, 32'h00000001);
        wr(3'd6, 32'h0);
        #0.5; chk("R10 warn set", 32'(comp_warn), 32'h1);
        wr(3'd6, 32'h1);
        #0.5; chk("R10 warn masked", 32'(comp_warn), 32'h0);
        wr(3'd6, 32'h0);
        wr(3'd2, 32'h0);
        #0.5; chk("R10 no top grade", 32'(comp_warn), 32'h0);

        // R11 input synchronizer latency and analog masking
        wr(3'd0, 32'h44444444);
        wr(3'd1, 32'h44444444);
        @(negedge clk);
        pad_in = 16'hA5C3;
        @(negedge clk); @(negedge clk);
        rd(3'd4, r); chk("R11 two edges", r, 32'h0);
        @(negedge clk);
        rd(3'd4, r); chk("R11 three edges", r, 32'h0000A5C3);
        wr(3'd0, 32'h44444400);
        @(negedge clk); @(negedge clk);
        rd(3'd4, r); chk("R11 analog zero", r, 32'h0000A5C0);

        // R12 set/clear
        wr(3'd3, 32'h000000FF);
        rd(3'd3, r); chk("R12 direct", r, 32'h000000FF);
        wr(3'd5, 32'h0F0F0300);
        rd(3'd3, r); chk("R12 set/clear", r, 32'h000003F0);
        wr(3'd5, 32'h00010001);
        rd(3'd3, r); chk("R12 set wins", r, 32'h000003F1);
        rd(3'd5, r); chk("R12 reads zero", r, 32'h0);
        wr(3'd2, 32'h0000BEEF);
        rd(3'd2, r); chk("R13 speed readback", r, 32'h0000BEEF);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule